// File: doc/BRIEF.md
# UART Receive FIFO with Trigger Levels and Character Timeout

This block sits between a UART's bit-level deserializer and the host register file. It queues received bytes in a 16-entry circular buffer, or in a single holding byte when queueing is switched off. It keeps the receive status flags: data present, overrun and break. It raises a flag once the queue reaches a programmable fill level. A character-timeout detector flags bytes that have sat in the queue with no host read for four character times.

The host drives one strobe to pop a byte, one strobe that stands for a line-status read, and a write port for the queue control byte. The line format field gives the frame length. The timeout counts baud ticks at sixteen per bit, so the interval is 64 ticks per frame bit. The interrupt priority encoder downstream consumes the trigger and timeout flags.

Top module: `uart_rx_fifo`

## Requirements
- R1: After reset, data_ready, overrun, brk_seen, trig_hit and tmo_pend are 0, ctl_value is 0x00 (single-byte mode) and rd_data is 0x00.
- R2: In queue mode (ctl_value bit 0 = 1), rd_data shows the oldest byte, bytes leave in arrival order on rd_strobe, and rd_data is 0x00 while the queue is empty.
- R3: In queue mode, trig_hit is 1 exactly when the number of queued bytes is at least the level chosen by control bits 7:6: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14. In single-byte mode trig_hit equals data_ready.
- R4: A byte that arrives while the queue holds 16 bytes is dropped, the queued bytes are kept unchanged, and overrun is set.
- R5: In single-byte mode, a byte that arrives while data_ready is 1 and no read is taking place sets overrun and replaces the held byte.
- R6: A break strobe acts as a received 0x00 byte and also sets brk_seen and data_ready. When rx_valid and rx_break come together, the break wins.
- R7: A read that leaves the queue empty, or any read in single-byte mode, clears data_ready and brk_seen.
- R8: stat_rd clears overrun and brk_seen and leaves data_ready unchanged. A flag set in the same cycle stays set.
- R9: In queue mode, each received byte restarts the timeout timer, and so does a read that leaves bytes behind. tmo_pend rises on the Nth baud tick after the restart, where N is 64 times the frame length, provided the queue is not empty at that moment.
- R10: The frame length in bits is 1 + (line_fmt[1:0] + 5) + line_fmt[3] + (2 if line_fmt[2] else 1).
- R11: Any rd_strobe clears tmo_pend in the next cycle.
- R12: A control write keeps only bits 7:6, 3 and 0 (mask 0xC9) in ctl_value. Setting bit 1 empties the queue. Changing bit 0 also empties it. Emptying clears data_ready, brk_seen, the timer and tmo_pend.
- R13: A control write whose value equals ctl_value is ignored, so it neither empties the queue nor alters any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | A received byte is on rx_byte this cycle |
| rx_byte | input | 8 | Received byte |
| rx_break | input | 1 | Break condition detected on the line this cycle |
| rd_strobe | input | 1 | Host pops the byte shown on rd_data |
| stat_rd | input | 1 | Host reads line status; clears overrun and break |
| ctl_wr | input | 1 | Write strobe for the control byte |
| ctl_wdata | input | 8 | Control byte: 7:6 trigger, 3 kept, 2 transmit reset, 1 receive reset, 0 enable |
| line_fmt | input | 4 | Frame format: 1:0 data length minus 5, 2 two stop bits, 3 parity present |
| baud_tick | input | 1 | One pulse per 1/16 bit time |
| rd_data | output | 8 | Oldest queued byte or held byte |
| ctl_value | output | 8 | Retained control bits |
| data_ready | output | 1 | At least one byte available |
| overrun | output | 1 | A byte was lost |
| brk_seen | output | 1 | A break was received |
| trig_hit | output | 1 | Fill level reached |
| tmo_pend | output | 1 | Character timeout pending |

## Verification
The trigger flag is swept over every fill count from 0 to 16 under each of the four level codes, so an off-by-one in any threshold, or a swapped code, is caught. Each of those fills runs into overflow and is then fully drained, which separates dropping from overwriting and confirms arrival order. The timeout is probed one tick before and at its expiry for all sixteen frame formats, which tells a wrong frame-length term from a wrong scale. Directed sequences cover single-byte replacement, breaks, status-read clearing, restart by a partial read, an equal control write against a flushing one, and a timer armed on a queue that is then emptied.

// File: rtl/uart_rx_fifo_pkg.sv
// Shared constants and helpers for the receive queue.
// Assumes an 8-bit character path.
package uart_rx_fifo_pkg;

    // Control bits that the queue keeps after a write
    localparam logic [7:0] CTL_KEEP_MASK = 8'hC9;
    localparam int         CTL_EN_BIT    = 0;
    localparam int         CTL_RXRST_BIT = 1;

    typedef enum logic [1:0] {
        LVL_ONE      = 2'b00,
        LVL_FOUR     = 2'b01,
        LVL_EIGHT    = 2'b10,
        LVL_FOURTEEN = 2'b11
    } trig_sel_e;

    // Fill threshold for a trigger code
    function automatic int unsigned trig_level(input trig_sel_e sel);
        case (sel)
            LVL_ONE:   return 1;
            LVL_FOUR:  return 4;
            LVL_EIGHT: return 8;
            default:   return 14;
        endcase
    endfunction

    // Bits per frame: start + data + optional parity + stop
    function automatic logic [3:0] frame_bits(input logic [3:0] fmt);
        logic [3:0] n;
        n = 4'd6 + {2'b00, fmt[1:0]} + {3'b000, fmt[3]} + (fmt[2] ? 4'd2 : 4'd1);
        return n;
    endfunction

endpackage

// File: rtl/uart_rx_fifo_ctrl.sv
// Queue control register.
// Keeps the sticky control bits and ignores a write of the stored value.
// Requests a receive flush on the reset bit or on an enable change.
module uart_rx_fifo_ctrl
    import uart_rx_fifo_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [7:0] wdata,
    output logic [7:0] ctl_q,
    output logic       fifo_en,
    output trig_sel_e  trig_sel,
    output logic       rx_flush
);

    logic accept;
    logic en_change;

    // Decide whether a write takes effect and whether it flushes
    always_comb begin
        accept    = wr && (wdata != ctl_q);
        en_change = wdata[CTL_EN_BIT] ^ ctl_q[CTL_EN_BIT];
        rx_flush  = accept && (wdata[CTL_RXRST_BIT] || en_change);
    end

    // Store the sticky bits of an accepted write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= 8'h00;
        end else if (accept) begin
            ctl_q <= wdata & CTL_KEEP_MASK;
        end
    end

    assign fifo_en  = ctl_q[CTL_EN_BIT];
    assign trig_sel = trig_sel_e'(ctl_q[7:6]);

    AST_KEEP_ONLY_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> ((ctl_q & ~CTL_KEEP_MASK) == 8'h00)); // R12

endmodule

// File: rtl/uart_rx_fifo_store.sv
// Circular byte buffer with an occupancy count.
// Assumes DEPTH is a power of two. A push into a full buffer is dropped.
// A pop of an empty buffer does nothing. The head reads as zero when empty.
module uart_rx_fifo_store #(
    parameter  int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [7:0]       wbyte,
    input  logic             pop,
    output logic [7:0]       head,
    output logic [CNT_W-1:0] count,
    output logic             full
);

    logic [7:0]       mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             do_push;
    logic             do_pop;

    // Qualify the requests against the occupancy
    always_comb begin
        full    = (count == CNT_W'(DEPTH));
        do_push = push && !full;
        do_pop  = pop && (count != '0);
        head    = (count == '0) ? 8'h00 : mem[rd_ptr];
    end

    // Move the pointers and the count
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + PTR_W'(1);
            if (do_pop)  rd_ptr <= rd_ptr + PTR_W'(1);
            if (do_push && !do_pop)      count <= count + CNT_W'(1);
            else if (do_pop && !do_push) count <= count - CNT_W'(1);
        end
    end

    // Write the storage cell
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wbyte;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> (count == CNT_W'(DEPTH))); // R4
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0)); // R12

endmodule

// File: rtl/uart_rx_fifo_timer.sv
// Character-timeout timer.
// Counts baud ticks from its last restart. On reaching the limit it disarms,
// and it flags a timeout if bytes are still queued. A stop or a host read
// clears the flag.
module uart_rx_fifo_timer #(
    parameter int LIM_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stop,
    input  logic             restart,
    input  logic             tick,
    input  logic [LIM_W-1:0] limit,
    input  logic             occupied,
    input  logic             clr,
    output logic             pend
);

    logic [LIM_W-1:0] cnt;
    logic             armed;
    logic             expire;

    // Detect the tick that completes the interval
    always_comb begin
        expire = armed && tick && !restart && (cnt >= limit - LIM_W'(1));
    end

    // Run the tick counter
    always_ff @(posedge clk) begin
        if (!rst_n || stop) begin
            armed <= 1'b0;
            cnt   <= '0;
        end else if (restart) begin
            armed <= 1'b1;
            cnt   <= '0;
        end else if (expire) begin
            armed <= 1'b0;
            cnt   <= '0;
        end else if (armed && tick) begin
            cnt <= cnt + LIM_W'(1);
        end
    end

    // Hold the pending flag
    always_ff @(posedge clk) begin
        if (!rst_n || stop || clr) begin
            pend <= 1'b0;
        end else if (expire && occupied) begin
            pend <= 1'b1;
        end
    end

    AST_CLR_DROPS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !pend); // R11
    AST_PEND_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> $past(occupied)); // R9

endmodule

// File: rtl/uart_rx_fifo.sv
// Receive queue of a UART with trigger levels and a character timeout.
// Takes bytes and break strobes from the deserializer and host strobes from
// the register file. rd_data is valid in the cycle rd_strobe is high.
// Assumes DEPTH is a power of two of at least 16.
module uart_rx_fifo
    import uart_rx_fifo_pkg::*;
#(
    parameter int DEPTH         = 16,
    parameter int TICKS_PER_BIT = 16,
    parameter int CHAR_SPAN     = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    input  logic       rx_break,
    input  logic       rd_strobe,
    input  logic       stat_rd,
    input  logic       ctl_wr,
    input  logic [7:0] ctl_wdata,
    input  logic [3:0] line_fmt,
    input  logic       baud_tick,
    output logic [7:0] rd_data,
    output logic [7:0] ctl_value,
    output logic       data_ready,
    output logic       overrun,
    output logic       brk_seen,
    output logic       trig_hit,
    output logic       tmo_pend
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int SCALE = TICKS_PER_BIT * CHAR_SPAN;
    localparam int LIM_W = $clog2(SCALE * 12 + 1);

    logic             fifo_en;
    trig_sel_e        trig_sel;
    logic             rx_flush;
    logic [7:0]       head;
    logic [CNT_W-1:0] count;
    logic             full;
    logic             evt;
    logic [7:0]       evt_byte;
    logic             push;
    logic             pop;
    logic             restart;
    logic [LIM_W-1:0] tmo_limit;
    logic [CNT_W-1:0] lvl;
    logic [7:0]       hold, hold_n;
    logic             dr_n, oe_n, bi_n;

    uart_rx_fifo_ctrl i_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (ctl_wr),
        .wdata    (ctl_wdata),
        .ctl_q    (ctl_value),
        .fifo_en  (fifo_en),
        .trig_sel (trig_sel),
        .rx_flush (rx_flush)
    );

    uart_rx_fifo_store #(.DEPTH(DEPTH)) i_store (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (rx_flush),
        .push  (push),
        .wbyte (evt_byte),
        .pop   (pop),
        .head  (head),
        .count (count),
        .full  (full)
    );

    uart_rx_fifo_timer #(.LIM_W(LIM_W)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .stop     (rx_flush),
        .restart  (restart),
        .tick     (baud_tick),
        .limit    (tmo_limit),
        .occupied (count != '0),
        .clr      (rd_strobe),
        .pend     (tmo_pend)
    );

    // Steer arriving bytes, host pops and timer restarts
    always_comb begin
        evt       = rx_valid || rx_break;
        evt_byte  = rx_break ? 8'h00 : rx_byte;
        push      = fifo_en && evt && !rx_flush;
        pop       = fifo_en && rd_strobe && !rx_flush;
        restart   = fifo_en && !rx_flush && (evt || (pop && (count > CNT_W'(1))));
        tmo_limit = LIM_W'(SCALE) * LIM_W'(frame_bits(line_fmt));
        lvl       = CNT_W'(trig_level(trig_sel));
    end

    // Next values of the receive status flags and the holding byte
    always_comb begin
        dr_n   = data_ready;
        oe_n   = overrun;
        bi_n   = brk_seen;
        hold_n = hold;
        if (stat_rd) begin
            oe_n = 1'b0;
            bi_n = 1'b0;
        end
        if (rx_flush) begin
            dr_n = 1'b0;
            bi_n = 1'b0;
        end else if (fifo_en) begin
            if (rd_strobe && (count <= CNT_W'(1))) begin
                dr_n = 1'b0;
                bi_n = 1'b0;
            end
            if (evt) begin
                dr_n = 1'b1;
                if (rx_break) bi_n = 1'b1;
                if (full)     oe_n = 1'b1;
            end
        end else begin
            if (rd_strobe) begin
                dr_n = 1'b0;
                bi_n = 1'b0;
            end
            if (evt) begin
                if (data_ready && !rd_strobe) oe_n = 1'b1;
                hold_n = evt_byte;
                dr_n   = 1'b1;
                if (rx_break) bi_n = 1'b1;
            end
        end
    end

    // Register the status flags and the holding byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_ready <= 1'b0;
            overrun    <= 1'b0;
            brk_seen   <= 1'b0;
            hold       <= 8'h00;
        end else begin
            data_ready <= dr_n;
            overrun    <= oe_n;
            brk_seen   <= bi_n;
            hold       <= hold_n;
        end
    end

    // Present the read byte and the trigger flag
    always_comb begin
        rd_data  = fifo_en ? head : hold;
        trig_hit = fifo_en ? (data_ready && (count >= lvl)) : data_ready;
    end

    AST_STATUS_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !rx_valid && !rx_break) |=> (!overrun && !brk_seen)); // R8
    AST_BREAK_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_break && !rx_flush) |=> (brk_seen && data_ready)); // R6
    AST_SINGLE_REPLACE: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && !ctl_wr && rx_valid && !rx_break && data_ready && !rd_strobe)
        |=> (overrun && rd_data == $past(rx_byte))); // R5
    AST_LAST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && rd_strobe && count == CNT_W'(1) && !evt && !rx_flush)
        |=> !data_ready); // R7
    AST_SAME_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_wdata == ctl_value && !evt && !rd_strobe) |=> $stable(count)); // R13

endmodule

// File: tb/test_uart_rx_fifo.sv
// Self-checking bench for uart_rx_fifo: sweeps trigger codes over every fill
// level and the timeout over every frame format, plus directed corner cases.
module test_uart_rx_fifo;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       rx_break = 1'b0;
    logic       rd_strobe = 1'b0;
    logic       stat_rd = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_wdata = 8'h00;
    logic [3:0] line_fmt = 4'h3;
    logic       baud_tick = 1'b0;
    logic [7:0] rd_data, ctl_value;
    logic       data_ready, overrun, brk_seen, trig_hit, tmo_pend;

    int errs = 0;
    int checks = 0;

    always #4 clk = ~clk;

    uart_rx_fifo i_uart_rx_fifo (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rx_break(rx_break), .rd_strobe(rd_strobe), .stat_rd(stat_rd),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .line_fmt(line_fmt),
        .baud_tick(baud_tick), .rd_data(rd_data), .ctl_value(ctl_value),
        .data_ready(data_ready), .overrun(overrun), .brk_seen(brk_seen),
        .trig_hit(trig_hit), .tmo_pend(tmo_pend)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push_b(input logic [7:0] b);
        @(negedge clk); rx_valid = 1'b1; rx_byte = b;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic brk_in();
        @(negedge clk); rx_break = 1'b1;
        @(negedge clk); rx_break = 1'b0;
    endtask

    task automatic rd_b(output logic [7:0] d);
        @(negedge clk); rd_strobe = 1'b1; #1 d = rd_data;
        @(negedge clk); rd_strobe = 1'b0;
    endtask

    task automatic stat_read();
        @(negedge clk); stat_rd = 1'b1;
        @(negedge clk); stat_rd = 1'b0;
    endtask

    task automatic ctl_w(input logic [7:0] v);
        @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
        @(negedge clk); ctl_wr = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk); baud_tick = 1'b1;
        repeat (n) @(negedge clk);
        baud_tick = 1'b0;
    endtask

    function automatic int level_of(input int code);
        return (code == 0) ? 1 : (code == 1) ? 4 : (code == 2) ? 8 : 14;
    endfunction

    function automatic int limit_of(input int f);
        return 64 * (1 + (f % 4) + 5 + ((f >> 3) & 1) + (((f >> 2) & 1) != 0 ? 2 : 1));
    endfunction

    function automatic logic [7:0] pat(input int code, input int i);
        return 8'((code * 37 + i * 11 + 5) % 256);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 data_ready", data_ready, 0);
        check("R1 overrun", overrun, 0);
        check("R1 brk_seen", brk_seen, 0);
        check("R1 trig_hit", trig_hit, 0);
        check("R1 tmo_pend", tmo_pend, 0);
        check("R1 ctl_value", ctl_value, 8'h00);
        check("R1 rd_data", rd_data, 8'h00);

        // R5 single-byte mode replacement
        push_b(8'h5A);
        check("R5 ready", data_ready, 1);
        check("R3 single trig", trig_hit, 1);
        push_b(8'hA5);
        check("R5 overrun", overrun, 1);
        check("R5 replaced", rd_data, 8'hA5);
        stat_read();
        check("R8 overrun cleared", overrun, 0);
        check("R8 ready kept", data_ready, 1);
        rd_b(d);
        check("R5 read", d, 8'hA5);
        check("R7 single read clears", data_ready, 0);

        // R3 R4 R2 R7 sweep over every trigger code and fill
        for (int code = 0; code < 4; code++) begin
            ctl_w(8'(code << 6) | 8'h03);
            check("R12 ctl kept", ctl_value, 8'(code << 6) | 8'h01);
            for (int n = 0; n <= 16; n++) begin
                check($sformatf("R3 code%0d fill%0d", code, n), trig_hit, (n >= level_of(code)) ? 1 : 0);
                if (n < 16) push_b(pat(code, n));
            end
            push_b(8'hEE);
            check("R4 overrun on full", overrun, 1);
            stat_read();
            check("R8 overrun cleared", overrun, 0);
            for (int i = 0; i < 16; i++) begin
                rd_b(d);
                check("R2 R4 order kept", d, pat(code, i));
            end
            check("R7 ready after drain", data_ready, 0);
            rd_b(d);
            check("R2 empty reads zero", d, 8'h00);
        end

        // R6 break in queue mode and status read
        push_b(8'h33);
        brk_in();
        check("R6 brk", brk_seen, 1);
        check("R6 ready", data_ready, 1);
        rd_b(d);
        check("R6 first byte", d, 8'h33);
        check("R6 brk kept", brk_seen, 1);
        rd_b(d);
        check("R6 zero byte", d, 8'h00);
        check("R7 brk cleared", brk_seen, 0);
        brk_in();
        stat_read();
        check("R8 brk cleared", brk_seen, 0);
        check("R8 ready kept", data_ready, 1);
        rd_b(d);

        // R13 equal write ignored, R12 flush and mask
        push_b(8'h71);
        push_b(8'h72);
        ctl_w(ctl_value);
        check("R13 ready kept", data_ready, 1);
        check("R13 head kept", rd_data, 8'h71);
        ctl_w(8'hFF);
        check("R12 mask", ctl_value, 8'hC9);
        check("R12 flushed ready", data_ready, 0);
        check("R12 flushed data", rd_data, 8'h00);
        ctl_w(8'h03);
        check("R12 ctl", ctl_value, 8'h01);

        // R9 R10 R11 timeout over every frame format
        for (int f = 0; f < 16; f++) begin
            line_fmt = 4'(f);
            push_b(8'h40 + 8'(f));
            ticks(limit_of(f) - 1);
            check($sformatf("R10 fmt%0d early", f), tmo_pend, 0);
            ticks(1);
            check($sformatf("R9 R10 fmt%0d expiry", f), tmo_pend, 1);
            rd_b(d);
            check("R11 read clears", tmo_pend, 0);
            check("R2 timed byte", d, 8'h40 + 8'(f));
        end

        // R9 no timeout once emptied
        line_fmt = 4'h0;
        push_b(8'h11);
        rd_b(d);
        ticks(limit_of(0) + 4);
        check("R9 empty no pend", tmo_pend, 0);

        // R9 partial read restarts, R12 flush clears pend
        push_b(8'h21);
        push_b(8'h22);
        ticks(limit_of(0) - 1);
        rd_b(d);
        ticks(limit_of(0) - 1);
        check("R9 restart by read", tmo_pend, 0);
        ticks(1);
        check("R9 after restart", tmo_pend, 1);
        ctl_w(8'h03);
        check("R12 flush clears pend", tmo_pend, 0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule